// File: doc/BRIEF.md
# DMA Channel Error Capture Unit

This block watches one descriptor-driven DMA channel for faults and keeps a sticky record of them in a sixteen-bit error register. The fetch, read and write paths report faults as one-cycle strobes. The block also checks three things itself: the command words that software writes, the chain start address at the first descriptor fetch, and the completion address and interrupt configuration when each is needed.

A fault that stops the transfer moves the channel from Active to Halted and stores the address of the descriptor that failed. Software reads the flags, acknowledges them by writing ones to the error register, and brings the channel back to Idle with a reset command. A level interrupt request stays high for as long as any flag is set.

Top module: `dma_err_capture`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `err_flags` is 0, `chan_state` is Idle (0), `fail_addr` is 0 and `irq` is 0.
- R2: The error register bit positions are as follows. Bit 4 is the chain address error. Bit 5 is the command error. Bit 6 is chipset parity. Bit 7 is engine parity. Bit 8 is read data. Bit 9 is write data. Bit 10 is descriptor control. Bit 11 is descriptor length. Bit 12 is completion address. Bit 13 is interrupt configuration. All other bits, and bit 7, always read 0.
- R3: A flag, once set, stays set until a register write with `reg_sel`=1 carries a 1 in that bit position. A 0 bit in that write leaves the flag alone, and a command write (`reg_sel`=0) clears nothing. If a set event and a clear hit the same bit in the same cycle, the bit stays set.
- R4: A source parity strobe sets bits 6 and 8. A destination parity strobe sets bits 6 and 9.
- R5: A length, control, read, write or parity fault seen while the channel is Active moves it to Halted (2) and loads `desc_addr` into `fail_addr` on the next cycle. The same fault seen in Idle or Halted sets its flag but changes neither the state nor `fail_addr`.
- R6: A command write whose low `CMD_W` bits have more than one bit set sets bit 5 and changes nothing else. A command write of all zeros has no effect.
- R7: A command write with only bit 0 (start) set moves Idle to Active, and is ignored in the other states. A write with only bit 1 (reset) set moves any state to Idle. `fail_addr` keeps its value until the next halting fault.
- R8: On a first-fetch strobe, a chain address that is zero, or that has any of its low six bits set, sets bit 4.
- R9: On a completion-use strobe, a completion address that is zero, or that has any of its low six bits set, sets bit 12.
- R10: On an interrupt attempt, bit 13 is set when `intx_off` is 1 and `msi_en` and `msi_cb_en` are not both 1.
- R11: `irq` is 1 exactly when `err_flags` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_first_fetch | input | 1 | Initial descriptor fetch strobe |
| ev_len_bad | input | 1 | Illegal descriptor length |
| ev_ctrl_bad | input | 1 | Illegal descriptor control field |
| ev_rd_fault | input | 1 | Source data access fault |
| ev_wr_fault | input | 1 | Destination data write fault |
| ev_par_src | input | 1 | Chipset parity fault on source data |
| ev_par_dst | input | 1 | Chipset parity fault on destination data |
| ev_cmp_use | input | 1 | Completion address about to be used |
| ev_irq_try | input | 1 | Channel attempts an interrupt |
| desc_addr | input | AW | Address of the current descriptor |
| chain_addr | input | AW | Configured chain start address |
| cmp_addr | input | AW | Configured completion address |
| msi_en | input | 1 | Message interrupt enable |
| msi_cb_en | input | 1 | Message completion-callback enable |
| intx_off | input | 1 | Legacy wire interrupt disabled |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 the error register |
| reg_wdata | input | 16 | Write data |
| err_flags | output | 16 | Error register value |
| chan_state | output | 2 | Channel state: 0 Idle, 1 Active, 2 Halted |
| fail_addr | output | AW | Descriptor address captured at the last halt |
| irq | output | 1 | Level interrupt request |

## Verification
All 256 command byte values are written from Idle. This separates the single-bit start and reset words from the zero word and from every multi-bit word, which must raise only the command flag. Both address checks run over the 256 smallest address values, so zero, the aligned multiples of 64 and every misaligned offset each give their own expected flag. All eight interrupt-enable combinations are tried. Each of the six halting strobes is fired in Active, then again in Halted and in Idle, which shows that only the Active case moves the state and reloads the captured address. Clear writes with zero bits, with bit 7, from the command register, and in the same cycle as a set event show the sticky rule apart from plain overwrite.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;

  localparam int REG_W = 16;

  // error register bit positions (software decodes these)
  localparam int B_CHAIN = 4;
  localparam int B_CMD   = 5;
  localparam int B_CPAR  = 6;
  localparam int B_EPAR  = 7;
  localparam int B_RD    = 8;
  localparam int B_WR    = 9;
  localparam int B_CTRL  = 10;
  localparam int B_LEN   = 11;
  localparam int B_CMP   = 12;
  localparam int B_INT   = 13;

  // implemented flags: bits 13..4 except the engine parity bit
  localparam logic [REG_W-1:0] FLAG_MASK =
    REG_W'(((1 << (B_INT + 1)) - (1 << B_CHAIN)) & ~(1 << B_EPAR));

  // command bit positions
  localparam int C_START = 0;
  localparam int C_RESET = 1;

  typedef enum logic [1:0] {
    CH_IDLE   = 2'd0,
    CH_ACTIVE = 2'd1,
    CH_HALTED = 2'd2
  } ch_state_e;

endpackage

// File: rtl/dma_cmd_check.sv
module dma_cmd_check #(
  parameter int CMD_W = 8
) (
  input  logic [CMD_W-1:0] cmd,
  input  logic             cmd_wr,
  output logic             multi_err,
  output logic             do_start,
  output logic             do_reset
);
  import dma_err_pkg::*;

  logic [CMD_W-1:0] low_cleared;
  logic             is_multi;
  logic             is_single;

  // clearing the lowest set bit leaves a nonzero value only if two or more were set
  always_comb begin
    low_cleared = cmd & (cmd - CMD_W'(1));
    is_multi    = |low_cleared;
    is_single   = (|cmd) && !is_multi;
  end

  generate
    if (CMD_W > C_RESET) begin : g_cmds
      always_comb begin
        multi_err = cmd_wr && is_multi;
        do_start  = cmd_wr && is_single && cmd[C_START];
        do_reset  = cmd_wr && is_single && cmd[C_RESET];
      end
    end else begin : g_start_only
      always_comb begin
        multi_err = cmd_wr && is_multi;
        do_start  = cmd_wr && is_single && cmd[C_START];
        do_reset  = 1'b0;
      end
    end
  endgenerate

endmodule

// File: rtl/dma_addr_check.sv
module dma_addr_check #(
  parameter int AW         = 32,
  parameter int ALIGN_BITS = 6
) (
  input  logic [AW-1:0] addr,
  output logic          bad
);
  localparam logic [AW-1:0] LOW_MASK = AW'((1 << ALIGN_BITS) - 1);

  logic unset;
  logic misaligned;

  always_comb begin
    unset      = (addr == '0);
    misaligned = |(addr & LOW_MASK);
    bad        = unset || misaligned;
  end

endmodule

// File: rtl/dma_err_flags.sv
module dma_err_flags
  import dma_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_data,
  output logic [REG_W-1:0] flag_q
);

  logic [REG_W-1:0] flag_d;

  generate
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
      // set has priority over a same-cycle clear
      assign flag_d[b] = FLAG_MASK[b] &
                         (set_vec[b] | (flag_q[b] & ~(clr_en & clr_data[b])));
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  // R3: with no clear write, no flag that was set can drop
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

  // R3: every implemented bit that was set is visible one cycle later, clear or not
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=>
      ((flag_q & $past(set_vec) & FLAG_MASK) == ($past(set_vec) & FLAG_MASK)));

endmodule

// File: rtl/dma_chan_fsm.sv
module dma_chan_fsm
  import dma_err_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          do_start,
  input  logic          do_reset,
  input  logic          halt_ev,
  input  logic [AW-1:0] desc_addr,
  output ch_state_e     state_q,
  output logic [AW-1:0] fail_addr_q
);

  ch_state_e     state_d;
  logic [AW-1:0] fail_addr_d;
  logic          halt_now;
  logic          addr_en;

  always_comb begin
    state_d  = state_q;
    halt_now = (state_q == CH_ACTIVE) && halt_ev && !do_reset;
    addr_en  = halt_now;
    if (do_reset) begin
      state_d = CH_IDLE;
    end else if (halt_now) begin
      state_d = CH_HALTED;
    end else if (do_start && (state_q == CH_IDLE)) begin
      state_d = CH_ACTIVE;
    end
    fail_addr_d = addr_en ? desc_addr : fail_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= CH_IDLE;
      fail_addr_q <= '0;
    end else begin
      state_q     <= state_d;
      fail_addr_q <= fail_addr_d;
    end
  end

  // R5: a fault in Active halts the channel and captures the descriptor
  p_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CH_ACTIVE && halt_ev && !do_reset) |=>
      (state_q == CH_HALTED && fail_addr_q == $past(desc_addr)));

  // R7: captured address holds unless an Active fault occurs
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(state_q == CH_ACTIVE && halt_ev) |=> $stable(fail_addr_q));

  // R7: a reset command always lands in Idle
  p_reset_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_reset |=> state_q == CH_IDLE);

endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_err_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CMD_W      = 8,
  parameter int ALIGN_BITS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_first_fetch,
  input  logic             ev_len_bad,
  input  logic             ev_ctrl_bad,
  input  logic             ev_rd_fault,
  input  logic             ev_wr_fault,
  input  logic             ev_par_src,
  input  logic             ev_par_dst,
  input  logic             ev_cmp_use,
  input  logic             ev_irq_try,
  input  logic [AW-1:0]    desc_addr,
  input  logic [AW-1:0]    chain_addr,
  input  logic [AW-1:0]    cmp_addr,
  input  logic             msi_en,
  input  logic             msi_cb_en,
  input  logic             intx_off,
  input  logic             reg_wr,
  input  logic             reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] err_flags,
  output logic [1:0]       chan_state,
  output logic [AW-1:0]    fail_addr,
  output logic             irq
);

  logic             cmd_wr;
  logic             clr_en;
  logic             multi_err;
  logic             do_start;
  logic             do_reset;
  logic             chain_bad;
  logic             cmp_bad;
  logic             irq_cfg_bad;
  logic             halt_ev;
  logic [REG_W-1:0] set_vec;
  ch_state_e        state_q;

  always_comb begin
    cmd_wr = reg_wr && !reg_sel;
    clr_en = reg_wr && reg_sel;
  end

  dma_cmd_check #(.CMD_W(CMD_W)) i_cmd (
    .cmd       (reg_wdata[CMD_W-1:0]),
    .cmd_wr    (cmd_wr),
    .multi_err (multi_err),
    .do_start  (do_start),
    .do_reset  (do_reset)
  );

  dma_addr_check #(.AW(AW), .ALIGN_BITS(ALIGN_BITS)) i_chain_chk (
    .addr (chain_addr),
    .bad  (chain_bad)
  );

  dma_addr_check #(.AW(AW), .ALIGN_BITS(ALIGN_BITS)) i_cmp_chk (
    .addr (cmp_addr),
    .bad  (cmp_bad)
  );

  always_comb begin
    irq_cfg_bad = intx_off && !(msi_en && msi_cb_en);
    halt_ev     = ev_len_bad | ev_ctrl_bad | ev_rd_fault | ev_wr_fault |
                  ev_par_src | ev_par_dst;

    set_vec          = '0;
    set_vec[B_CHAIN] = ev_first_fetch && chain_bad;
    set_vec[B_CMD]   = multi_err;
    set_vec[B_CPAR]  = ev_par_src | ev_par_dst;
    set_vec[B_RD]    = ev_rd_fault | ev_par_src;
    set_vec[B_WR]    = ev_wr_fault | ev_par_dst;
    set_vec[B_CTRL]  = ev_ctrl_bad;
    set_vec[B_LEN]   = ev_len_bad;
    set_vec[B_CMP]   = ev_cmp_use && cmp_bad;
    set_vec[B_INT]   = ev_irq_try && irq_cfg_bad;
  end

  dma_err_flags i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (set_vec),
    .clr_en   (clr_en),
    .clr_data (reg_wdata),
    .flag_q   (err_flags)
  );

  dma_chan_fsm #(.AW(AW)) i_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .do_start    (do_start),
    .do_reset    (do_reset),
    .halt_ev     (halt_ev),
    .desc_addr   (desc_addr),
    .state_q     (state_q),
    .fail_addr_q (fail_addr)
  );

  always_comb begin
    chan_state = state_q;
    irq        = |err_flags;
  end

  // R4: source parity reports on both the parity and read flags
  p_par_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_par_src |=> (err_flags[B_CPAR] && err_flags[B_RD]));

  // R4: destination parity reports on both the parity and write flags
  p_par_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_par_dst |=> (err_flags[B_CPAR] && err_flags[B_WR]));

  // R6: a multi-bit command raises the command flag and leaves the state alone
  p_multi_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && $countones(reg_wdata[CMD_W-1:0]) > 1 && !halt_ev) |=>
      (err_flags[B_CMD] && $stable(chan_state)));

  // R11: the request drops only after a clearing write
  p_irq_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(clr_en));

endmodule

// File: tb/test_dma_err_capture.sv
module test_dma_err_capture;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ev_first_fetch, ev_len_bad, ev_ctrl_bad, ev_rd_fault, ev_wr_fault;
  logic          ev_par_src, ev_par_dst, ev_cmp_use, ev_irq_try;
  logic [AW-1:0] desc_addr, chain_addr, cmp_addr;
  logic          msi_en, msi_cb_en, intx_off;
  logic          reg_wr, reg_sel;
  logic [15:0]   reg_wdata;
  logic [15:0]   err_flags;
  logic [1:0]    chan_state;
  logic [AW-1:0] fail_addr;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dma_err_capture #(.AW(AW)) i_dma_err_capture (
    .clk(clk), .rst_n(rst_n),
    .ev_first_fetch(ev_first_fetch), .ev_len_bad(ev_len_bad), .ev_ctrl_bad(ev_ctrl_bad),
    .ev_rd_fault(ev_rd_fault), .ev_wr_fault(ev_wr_fault), .ev_par_src(ev_par_src),
    .ev_par_dst(ev_par_dst), .ev_cmp_use(ev_cmp_use), .ev_irq_try(ev_irq_try),
    .desc_addr(desc_addr), .chain_addr(chain_addr), .cmp_addr(cmp_addr),
    .msi_en(msi_en), .msi_cb_en(msi_cb_en), .intx_off(intx_off),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .err_flags(err_flags), .chan_state(chan_state), .fail_addr(fail_addr), .irq(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // inputs were driven at a falling edge; one rising edge, then sample at the next fall
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    {ev_first_fetch, ev_len_bad, ev_ctrl_bad, ev_rd_fault, ev_wr_fault} = '0;
    {ev_par_src, ev_par_dst, ev_cmp_use, ev_irq_try} = '0;
    reg_wr = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    step();
  endtask

  task automatic fire(input int k);
    case (k)
      0: ev_len_bad  = 1'b1;
      1: ev_ctrl_bad = 1'b1;
      2: ev_rd_fault = 1'b1;
      3: ev_wr_fault = 1'b1;
      4: ev_par_src  = 1'b1;
      default: ev_par_dst = 1'b1;
    endcase
    step();
  endtask

  function automatic logic [15:0] fire_flags(input int k);
    case (k)
      0: return 16'h0800;
      1: return 16'h0400;
      2: return 16'h0100;
      3: return 16'h0200;
      4: return 16'h0140;
      default: return 16'h0240;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ev_first_fetch, ev_len_bad, ev_ctrl_bad, ev_rd_fault, ev_wr_fault} = '0;
    {ev_par_src, ev_par_dst, ev_cmp_use, ev_irq_try} = '0;
    desc_addr = '0; chain_addr = 32'h40; cmp_addr = 32'h80;
    msi_en = 1'b1; msi_cb_en = 1'b1; intx_off = 1'b0;
    reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", err_flags, 0);
    chk("R1 state in reset", chan_state, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", err_flags, 0);
    chk("R1 state", chan_state, 0);
    chk("R1 fail_addr", fail_addr, 0);
    chk("R1 irq", irq, 0);

    // R6 / R7: every command byte from Idle
    for (int v = 0; v < 256; v++) begin
      wr(1'b0, 16'(v));
      chk("R6 command flag", err_flags, ($countones(v) > 1) ? 16'h0020 : 16'h0000);
      chk("R7 command state", chan_state, (v == 1) ? 2'd1 : 2'd0);
      chk("R11 irq after command", irq, ($countones(v) > 1) ? 1'b1 : 1'b0);
      wr(1'b0, 16'h0002);
      wr(1'b1, 16'hFFFF);
    end

    // R8: chain alignment sweep at the first fetch
    for (int a = 0; a < 256; a++) begin
      chain_addr = 32'(a); ev_first_fetch = 1'b1;
      step();
      chk("R8 chain flag", err_flags, (a == 0 || (a % 64) != 0) ? 16'h0010 : 16'h0000);
      wr(1'b1, 16'hFFFF);
    end
    // R8: a misaligned chain address without a fetch sets nothing
    chain_addr = 32'h41; step();
    chk("R8 no fetch no flag", err_flags, 0);

    // R9: completion address sweep
    for (int a = 0; a < 256; a++) begin
      cmp_addr = 32'(a); ev_cmp_use = 1'b1;
      step();
      chk("R9 completion flag", err_flags, (a == 0 || (a % 64) != 0) ? 16'h1000 : 16'h0000);
      wr(1'b1, 16'hFFFF);
    end

    // R10: all enable combinations
    for (int c = 0; c < 8; c++) begin
      intx_off = c[2]; msi_en = c[1]; msi_cb_en = c[0]; ev_irq_try = 1'b1;
      step();
      chk("R10 interrupt config flag", err_flags,
          (c[2] && !(c[1] && c[0])) ? 16'h2000 : 16'h0000);
      wr(1'b1, 16'hFFFF);
      chk("R3 clear all", err_flags, 0);
    end

    // R5 / R4 / R7: each halting fault
    for (int k = 0; k < 6; k++) begin
      wr(1'b0, 16'h0001);
      chk("R7 start from Idle", chan_state, 1);
      desc_addr = 32'h1000_0040 + 32'(k * 64);
      fire(k);
      chk("R5 halted", chan_state, 2);
      chk("R5 captured address", fail_addr, 32'h1000_0040 + 32'(k * 64));
      chk("R4 R5 fault flags", err_flags, fire_flags(k));
      wr(1'b0, 16'h0001);
      chk("R7 start ignored in Halted", chan_state, 2);
      desc_addr = 32'hDEAD_0000;
      ev_len_bad = 1'b1; step();
      chk("R5 no recapture in Halted", fail_addr, 32'h1000_0040 + 32'(k * 64));
      chk("R5 length flag in Halted", err_flags[11], 1);
      wr(1'b0, 16'h0002);
      chk("R7 reset to Idle", chan_state, 0);
      chk("R7 address kept after reset", fail_addr, 32'h1000_0040 + 32'(k * 64));
      fire(k);
      chk("R5 Idle fault keeps state", chan_state, 0);
      chk("R5 Idle fault keeps address", fail_addr, 32'h1000_0040 + 32'(k * 64));
      wr(1'b1, 16'hFFFF);
      chk("R11 irq low after clear", irq, 0);
    end

    // R3: clear rules
    ev_len_bad = 1'b1; ev_ctrl_bad = 1'b1; step();
    chk("R3 two flags set", err_flags, 16'h0C00);
    wr(1'b1, 16'h0000);
    chk("R3 zero write keeps", err_flags, 16'h0C00);
    wr(1'b0, 16'hFFFF & 16'h0C00);
    chk("R3 command write clears nothing", err_flags, 16'h0C00);
    wr(1'b1, 16'h0080);
    chk("R2 bit 7 write no effect", err_flags, 16'h0C00);
    wr(1'b1, 16'h0800);
    chk("R3 selective clear", err_flags, 16'h0400);
    chk("R11 irq still high", irq, 1);
    ev_ctrl_bad = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'h0400;
    step();
    chk("R3 set wins over clear", err_flags, 16'h0400);
    wr(1'b1, 16'h0400);
    chk("R3 cleared", err_flags, 0);
    chk("R11 irq low", irq, 0);

    // R2: everything at once, only implemented bits appear
    wr(1'b0, 16'h0001);
    chain_addr = 32'h3; cmp_addr = 32'h0; intx_off = 1'b1; msi_en = 1'b0;
    {ev_first_fetch, ev_len_bad, ev_ctrl_bad, ev_rd_fault, ev_wr_fault} = '1;
    {ev_par_src, ev_par_dst, ev_cmp_use, ev_irq_try} = '1;
    step();
    wr(1'b0, 16'h0003);
    chk("R2 full register", err_flags, 16'h3F70);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule